// File: doc/BRIEF.md
# Limit Counter Timer with Reached Flag

This block is a word-addressed counter/timer. On every pulse of a tick-enable input it advances a 22-bit count. The tick input is meant to pulse once every 500 ns, and the count is presented in bits 30..9 of a 32-bit word. When the next count would reach the programmed limit, the count returns to zero, a sticky reached flag is set and a level interrupt is raised. The counter then keeps running, so a fixed limit gives a periodic interrupt.

Software talks to the block over a plain valid/write/address/data port. Read data is combinational while a read is presented. Side effects take place at the clock edge that ends the access. Offset 0 is the limit; reading it acknowledges the event. Offset 1 is the counter together with the reached flag. Offset 2 changes the limit without disturbing the running count. A limit of zero lets the counter free-run over the full 22-bit range.

Top module: `lct_timer`

## Requirements
- R1: After reset the limit, count, reached flag and interrupt are all zero, and the counter advances on the first tick with no further programming.
- R2: A read of offset 1 returns the reached flag in bit 31, the count in bits 30..9 and zeros in bits 8..0. The count rises by one on each clock edge where tick_i is high and holds otherwise.
- R3: On a tick where count+1 is greater than or equal to the effective limit, the count becomes zero and both the reached flag and irq_o become 1 at that same edge. Counting then continues.
- R4: A stored limit of zero selects free-running with an effective limit of 0x7FFFFE00 (all 22 count bits set).
- R5: A read of offset 0 returns the stored limit in bits 30..9 with the other bits zero. At the end of the access it clears the reached flag and irq_o, unless a wrap happens on that same edge, in which case both end up set.
- R6: A write to offset 0 stores wdata AND 0x7FFFFE00 as the limit, clears the count to zero and drops irq_o. It leaves the reached flag unchanged. A tick on the same edge is discarded.
- R7: A write to offset 2 stores wdata AND 0x7FFFFE00 as the limit and leaves the count, flag and irq_o alone. A tick on that edge still advances the count, compared against the old limit. A count already at or above the new limit wraps on the next tick.
- R8: Writes to offset 1 and to offsets 3..7 change nothing. Reads of offsets 2..7 return zero.
- R9: irq_o is a level. Once set, it stays high until a read or a write of offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per 500 ns time unit |
| bus_valid_i | input | 1 | Access present this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read is presented |
| irq_o | output | 1 | Level interrupt on limit reached |

## Verification
The bench uses limits of only a few units, so wraps happen often. It also lines up ticks with limit reads and limit writes on the same edge. A design that let the read-clear beat a simultaneous wrap would lose an event. A design that let a tick through on a limit write would show a count of one instead of zero.

Lowering the limit through offset 2 below the running count checks the greater-or-equal compare. An equality-only compare would instead run on for about four million ticks without an interrupt.

Free-run with limit zero checks that no interrupt fires early. Writing all ones checks the 0x7FFFFE00 mask on readback. Writes to offsets 1 and 5 are followed by readbacks that would expose any stray update.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_LIMIT = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_KEEP  = 3'd2;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_RD_LIM  = 2'd1,
        OP_WR_LIM  = 2'd2,
        OP_WR_KEEP = 2'd3
    } lct_op_e;
endpackage

// File: rtl/lct_decode.sv
module lct_decode
    import lct_pkg::*;
(
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output lct_op_e           op_o
);
    always_comb begin
        op_o = OP_NONE;
        if (valid_i) begin
            unique case (addr_i)
                OFF_LIMIT: op_o = write_i ? OP_WR_LIM : OP_RD_LIM;
                OFF_KEEP:  op_o = write_i ? OP_WR_KEEP : OP_NONE;
                default:   op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lct_core.sv
module lct_core
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  lct_op_e          op_i,
    input  logic [CNT_W-1:0] wlim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] FREE_LIM = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             flag;
        logic             irq;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] eff_lim;
    logic [CNT_W:0]   cnt_inc;
    logic             wrap;

    always_comb begin
        eff_lim = (st_q.lim == '0) ? FREE_LIM : st_q.lim;
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        wrap    = tick_i && (op_i != OP_WR_LIM) && (cnt_inc >= {1'b0, eff_lim});

        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = wrap ? '0 : cnt_inc[CNT_W-1:0];
        end
        unique case (op_i)
            OP_RD_LIM: begin
                st_d.flag = 1'b0;
                st_d.irq  = 1'b0;
            end
            OP_WR_LIM: begin
                st_d.lim = wlim_i;
                st_d.cnt = '0;
                st_d.irq = 1'b0;
            end
            OP_WR_KEEP: st_d.lim = wlim_i;
            default: ;
        endcase
        if (wrap) begin
            st_d.flag = 1'b1;
            st_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign lim_o  = st_q.lim;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/lct_rdmux.sv
module lct_rdmux
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W  = 22,
    parameter int unsigned LSB    = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  lim_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (valid_i && !write_i) begin
            unique case (addr_i)
                OFF_LIMIT: rdata_o = {1'b0, lim_i, {LSB{1'b0}}};
                OFF_COUNT: rdata_o = {flag_i, cnt_i, {LSB{1'b0}}};
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned LSB   = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   bus_valid_i,
    input  logic                   bus_write_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [CNT_W+LSB:0]     bus_wdata_i,
    output logic [CNT_W+LSB:0]     bus_rdata_o,
    output logic                   irq_o
);
    localparam int unsigned DATA_W = CNT_W + LSB + 1;

    lct_op_e          op;
    logic [CNT_W-1:0] cnt, lim;
    logic             flag;

    lct_decode u_decode (
        .valid_i (bus_valid_i),
        .write_i (bus_write_i),
        .addr_i  (bus_addr_i),
        .op_o    (op)
    );

    lct_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .op_i   (op),
        .wlim_i (bus_wdata_i[LSB +: CNT_W]),
        .cnt_o  (cnt),
        .lim_o  (lim),
        .flag_o (flag),
        .irq_o  (irq_o)
    );

    lct_rdmux #(.CNT_W(CNT_W), .LSB(LSB), .DATA_W(DATA_W)) u_rdmux (
        .valid_i (bus_valid_i),
        .write_i (bus_write_i),
        .addr_i  (bus_addr_i),
        .cnt_i   (cnt),
        .lim_i   (lim),
        .flag_i  (flag),
        .rdata_o (bus_rdata_o)
    );
endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned LSB   = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic                 bus_valid_i,
    input logic                 bus_write_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [CNT_W+LSB:0]   bus_rdata_o,
    input logic                 irq_o,
    input logic [CNT_W-1:0]     cnt,
    input logic                 flag
);
    logic rd_lim, wr_lim, wr_keep;
    assign rd_lim  = bus_valid_i && !bus_write_i && bus_addr_i == OFF_LIMIT;
    assign wr_lim  = bus_valid_i &&  bus_write_i && bus_addr_i == OFF_LIMIT;
    assign wr_keep = bus_valid_i &&  bus_write_i && bus_addr_i == OFF_KEEP;

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[LSB-1:0] == '0);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_lim) |=> $stable(cnt));

    p_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim |=> (!irq_o && cnt == '0));

    p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !tick_i) |=> (!irq_o && !flag));

    p_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_keep && !tick_i) |=> $stable(cnt));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && bus_addr_i >= OFF_KEEP) |-> bus_rdata_o == '0);

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_lim && !wr_lim) |=> irq_o);

    p_irq_has_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W), .LSB(LSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .cnt         (cnt),
    .flag        (flag)
);

// File: tb/test_lct_timer.sv
module test_lct_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        v = 1'b0, w = 1'b0;
    logic [2:0]  a = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [CW-1:0] mcnt = '0, mlim = '0;
    logic          mflag = 1'b0, mirq = 1'b0;

    lct_timer i_lct_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_valid_i(v), .bus_write_i(w), .bus_addr_i(a),
        .bus_wdata_i(wd), .bus_rdata_o(rd), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [2:0] off);
        case (off)
            3'd0:    return {1'b0, mlim, 9'b0};
            3'd1:    return {mflag, mcnt, 9'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic vv, input logic ww, input logic [2:0] aa,
                         input logic [31:0] dd, input logic tt);
        logic [CW-1:0] eff;
        logic wl, rl, kl, wr;
        eff = (mlim == '0) ? {CW{1'b1}} : mlim;
        wl = vv && ww && aa == 3'd0;
        rl = vv && !ww && aa == 3'd0;
        kl = vv && ww && aa == 3'd2;
        wr = tt && !wl && ({1'b0, mcnt} + 1 >= {1'b0, eff});
        if (tt) mcnt = wr ? '0 : mcnt + 1'b1;
        if (wl) begin mcnt = '0; mirq = 1'b0; end
        if (rl) begin mflag = 1'b0; mirq = 1'b0; end
        if (wl || kl) mlim = dd[30:9];
        if (wr) begin mflag = 1'b1; mirq = 1'b1; end
    endtask

    task automatic step(input logic vv, input logic ww, input logic [2:0] aa,
                        input logic [31:0] dd, input logic tt, input string req);
        @(negedge clk);
        v = vv; w = ww; a = aa; wd = dd; tick = tt;
        #1;
        if (vv && !ww) check(req, rd, exp_read(aa));
        @(posedge clk);
        #1;
        model(vv, ww, aa, dd, tt);
        v = 1'b0; tick = 1'b0;
        check("R9 irq", {31'b0, irq}, {31'b0, mirq});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        step(1, 0, 3'd0, 0, 0, "R1 limit");
        step(1, 0, 3'd1, 0, 0, "R1 count");
        step(0, 0, 3'd0, 0, 1, "R1 tick");
        step(1, 0, 3'd1, 0, 0, "R1 running");
        // mask on limit write
        step(1, 1, 3'd0, 32'hFFFF_FFFF, 0, "R6 wr");
        step(1, 0, 3'd0, 0, 0, "R6 mask");
        // limit 3: periodic wrap
        step(1, 1, 3'd0, 32'd3 << 9, 0, "R6");
        for (int i = 0; i < 7; i++) begin
            step(0, 0, 0, 0, 1, "R3");
            step(1, 0, 3'd1, 0, 0, "R3 count");
        end
        // wrap coincident with limit read: wrap wins
        step(1, 1, 3'd0, 32'd2 << 9, 0, "R6");
        step(0, 0, 0, 0, 1, "R3");
        step(1, 0, 3'd0, 0, 1, "R5 race");
        step(1, 0, 3'd1, 0, 0, "R5 flag kept");
        // tick with limit write dropped, flag kept
        step(1, 1, 3'd0, 32'd5 << 9, 1, "R6 tick drop");
        step(1, 0, 3'd1, 0, 0, "R6 count zero");
        // keep-limit write below count
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R2");
        step(1, 1, 3'd2, 32'd2 << 9, 0, "R7");
        step(1, 0, 3'd1, 0, 0, "R7 count kept");
        step(0, 0, 0, 0, 1, "R7 wrap");
        step(1, 0, 3'd1, 0, 0, "R7 after");
        // ignored writes and unmapped reads
        step(1, 1, 3'd1, 32'h1234_5600, 0, "R8");
        step(1, 1, 3'd5, 32'hFFFF_FFFF, 0, "R8");
        step(1, 0, 3'd1, 0, 0, "R8 count");
        step(1, 0, 3'd0, 0, 0, "R8 limit");
        step(1, 0, 3'd2, 0, 0, "R8 off2");
        step(1, 0, 3'd6, 0, 0, "R8 off6");
        // free run
        step(1, 1, 3'd0, 32'h0, 0, "R4");
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1, "R4");
        step(1, 0, 3'd1, 0, 0, "R4 free count");
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ra;
            logic [31:0] rdd;
            logic rv;
            rv  = ($urandom % 4) == 0;
            ra  = 3'($urandom % 8);
            if (ra > 3) ra = 3'($urandom % 8);
            rdd = ($urandom % 8 == 0) ? 32'h0 : (32'($urandom % 10 + 1) << 9) | ($urandom & 32'h8000_01FF);
            step(rv, rv && $urandom % 2 == 1, ra, rdd, $urandom % 2 == 1, "R2 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule